// File: doc/BRIEF.md
# Differential Clock Stop Controller

This block drives a set of differential clock pairs from one reference clock. Each pair has a true line, a complement line and one drive enable per line. The output clock is made by a phase flop that toggles on every reference edge, so one output period spans two reference cycles. A configuration mask marks which pairs may be stopped. Pairs outside the mask run all the time.

An asynchronous stop request passes through a two-flop synchronizer. The block then parks the stoppable pairs on a clean boundary. A mode bit selects the parked form: either the true line held high and driven with the complement released, or both lines released and low. When the request is withdrawn, a fixed resume latency runs. In the released mode, the true lines are driven high during that latency. All parked pairs then restart on one edge, each starting with a falling true line. The mask and mode are captured when a stop begins and are held until the pairs resume.

Top module: `dif_stop_ctl`

## Requirements
- R1: A pair whose captured mask bit is 0 always runs: true equals the phase flop, complement is its inverse, and both enables are 1. The phase flop is 0 in reset and toggles on every reference edge.
- R2: The stop request is sampled by two flops in series. A stop begins at the first edge after that at which the synchronized request is 1 and the phase flop is 0, so each stoppable true line completes its rising transition before it parks.
- R3: With mode bit cfg_park_float = 0, a parked pair holds true = 1 with its enable = 1, and complement = 0 with its enable = 0.
- R4: With cfg_park_float = 1, a parked pair has both lines at 0 and both enables at 0. A line whose enable is 0 always reads 0.
- R5: After the synchronized request falls, pairs resume at the first edge that comes at least RESUME_LAT (3) cycles later and at which the phase flop is 1. That is 3 or 4 reference cycles after the synchronized release. After this edge, true = 0 and complement = 1.
- R6: All parked pairs resume on the same edge.
- R7: In mode 1, every parked true line is driven to 1 with its enable at 1 from the cycle after the synchronized release until the resume edge.
- R8: The mask and mode bit are captured at the edge where a stop begins. Changes to them while pairs are parked have no effect until the pairs resume.
- R9: If the request is raised again before resume, the pairs stay parked and the latency count starts over at the next release.
- R10: In reset, every pair shows true = 0 and complement = 1, with both lines driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low reset |
| stop_req_a | input | 1 | Asynchronous stop request, active high |
| cfg_stoppable | input | NPAIR | Per-pair stop mask, 1 = may be parked |
| cfg_park_float | input | 1 | Parked form: 0 = true high and driven, 1 = both released |
| dif_t | output | NPAIR | True lines |
| dif_c | output | NPAIR | Complement lines |
| dif_t_oe | output | NPAIR | Drive enables of the true lines |
| dif_c_oe | output | NPAIR | Drive enables of the complement lines |

## Verification
The bench raises the request right after edge n, so the synchronized request is first seen at edge n+3. Parking therefore falls on edge n+3 or n+4, depending on the phase. A release driven after edge r is seen after edge r+2, and in mode 1 the true lines rise from that cycle. Resume comes at edge r+5 or r+6, whichever leaves the phase at 0. The bench tracks phase as the parity of its own count of edges since reset. It derives each of these edges for every scenario and compares every pair at the falling edge that follows each rising edge.

// File: rtl/dif_stop_ctl.sv
module dif_stop_ctl #(
  parameter int NPAIR      = 4,
  parameter int RESUME_LAT = 3
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             stop_req_a,
  input  logic [NPAIR-1:0] cfg_stoppable,
  input  logic             cfg_park_float,
  output logic [NPAIR-1:0] dif_t,
  output logic [NPAIR-1:0] dif_c,
  output logic [NPAIR-1:0] dif_t_oe,
  output logic [NPAIR-1:0] dif_c_oe
);
  localparam int CW = $clog2(RESUME_LAT + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(RESUME_LAT - 1);

  logic             sync1, stop_s;
  logic             phase, parked, hold_float;
  logic [NPAIR-1:0] hold_mask;
  logic [CW-1:0]    rel_cnt;
  logic             releasing, enter_go, resume_go;

  assign releasing = parked & ~stop_s;
  assign enter_go  = ~parked & stop_s & ~phase;
  assign resume_go = releasing & phase & (rel_cnt >= CNT_TOP);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= 1'b0;
      stop_s <= 1'b0;
      phase  <= 1'b0;
    end else begin
      sync1  <= stop_req_a;
      stop_s <= sync1;
      phase  <= ~phase;
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      parked     <= 1'b0;
      hold_mask  <= '0;
      hold_float <= 1'b0;
    end else if (enter_go) begin
      parked     <= 1'b1;
      hold_mask  <= cfg_stoppable;
      hold_float <= cfg_park_float;
    end else if (resume_go) begin
      parked <= 1'b0;
    end
  end

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n)                     rel_cnt <= '0;
    else if (!releasing || resume_go) rel_cnt <= '0;
    else if (rel_cnt < CNT_TOP)     rel_cnt <= rel_cnt + 1'b1;
  end

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    logic held;
    assign held = parked & hold_mask[g];
    always_comb begin
      if (!held) begin
        dif_t[g]    = phase;
        dif_c[g]    = ~phase;
        dif_t_oe[g] = 1'b1;
        dif_c_oe[g] = 1'b1;
      end else if (!hold_float) begin
        dif_t[g]    = 1'b1;
        dif_c[g]    = 1'b0;
        dif_t_oe[g] = 1'b1;
        dif_c_oe[g] = 1'b0;
      end else begin
        dif_t[g]    = releasing;
        dif_c[g]    = 1'b0;
        dif_t_oe[g] = releasing;
        dif_c_oe[g] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dif_stop_ctl_chk.sv
module dif_stop_ctl_chk #(
  parameter int NPAIR = 4
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic             stop_s,
  input logic             parked,
  input logic [NPAIR-1:0] hold_mask,
  input logic             hold_float,
  input logic [NPAIR-1:0] dif_t,
  input logic [NPAIR-1:0] dif_c,
  input logic [NPAIR-1:0] dif_t_oe,
  input logic [NPAIR-1:0] dif_c_oe
);
  for (genvar g = 0; g < NPAIR; g++) begin : g_chk
    AST_UNDRIVEN_TRUE_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !dif_t_oe[g] |-> !dif_t[g]); // R4
    AST_UNDRIVEN_COMP_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !dif_c_oe[g] |-> !dif_c[g]); // R4
    AST_DRIVEN_PAIR_OPPOSITE: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (dif_t_oe[g] && dif_c_oe[g]) |-> (dif_t[g] != dif_c[g])); // R1
    AST_PARK_HIGH_STEADY: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (parked && $past(parked) && hold_mask[g] && !hold_float) |-> ($stable(dif_t[g]) && dif_t_oe[g])); // R3
  end

  AST_RESUME_TOGETHER: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(parked) |-> ((&dif_t_oe) && (&dif_c_oe) && (dif_t == '0))); // R6
  AST_RESUME_LATENCY: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $fell(parked) |-> (!$past(stop_s) && !$past(stop_s, 2) && !$past(stop_s, 3))); // R5
  AST_ENTRY_AFTER_SYNC: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(parked) |-> $past(stop_s)); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (parked && $past(parked)) |-> ($stable(hold_mask) && $stable(hold_float))); // R8
endmodule

bind dif_stop_ctl dif_stop_ctl_chk #(.NPAIR(NPAIR)) u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .stop_s(stop_s), .parked(parked),
  .hold_mask(hold_mask), .hold_float(hold_float),
  .dif_t(dif_t), .dif_c(dif_c), .dif_t_oe(dif_t_oe), .dif_c_oe(dif_c_oe)
);

// File: tb/dif_stop_ctl_bench.sv
module dif_stop_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int NSC = 6;
  localparam int BIG = 1 << 30;

  localparam logic [N-1:0] SC_MASK  [NSC] = '{4'b0011, 4'b1111, 4'b0101, 4'b1110, 4'b0000, 4'b1001};
  localparam logic         SC_MODE  [NSC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [N-1:0] SC_MASK2 [NSC] = '{4'b0011, 4'b1111, 4'b1010, 4'b0001, 4'b0000, 4'b1001};
  localparam logic         SC_MODE2 [NSC] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam int           SC_HOLD  [NSC] = '{6, 5, 7, 4, 4, 5};
  localparam int           SC_GAP   [NSC] = '{3, 2, 5, 4, 3, 2};
  localparam logic         SC_RSTOP [NSC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

  logic clk_ref = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req_a = 1'b0;
  logic [N-1:0] cfg_stoppable = '0;
  logic cfg_park_float = 1'b0;
  logic [N-1:0] dif_t, dif_c, dif_t_oe, dif_c_oe;

  int n_vec = 0, n_bad = 0, cyc = 0;
  int E = BIG, R = BIG, r = BIG, pre_end = -1;
  logic [N-1:0] lm = '0;
  logic lmd = 1'b0;

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;
  always @(posedge clk_ref) if (rst_n) cyc <= cyc + 1;

  dif_stop_ctl #(.NPAIR(N), .RESUME_LAT(3)) u_dif_stop_ctl (
    .clk_ref(clk_ref), .rst_n(rst_n), .stop_req_a(stop_req_a),
    .cfg_stoppable(cfg_stoppable), .cfg_park_float(cfg_park_float),
    .dif_t(dif_t), .dif_c(dif_c), .dif_t_oe(dif_t_oe), .dif_c_oe(dif_c_oe));

  task automatic cmp(input string tag, input int p, input logic [3:0] got, input logic [3:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s pair %0d cycle %0d: got %b expected %b", tag, p, cyc, got, exp);
    end
  endtask

  task automatic check_all(input string ov);
    for (int i = 0; i < N; i++) begin
      logic ph;
      logic inwin;
      logic pre;
      logic [3:0] exp;
      string tag;
      ph    = cyc[0];
      inwin = (cyc >= E) && (cyc < R);
      pre   = (cyc >= r + 2) && (cyc <= pre_end);
      if (inwin && lm[i]) begin
        if (!lmd)     exp = 4'b1010;
        else if (pre) exp = 4'b1010;
        else          exp = 4'b0000;
      end else begin
        exp = {ph, ~ph, 2'b11};
      end
      if (inwin && !lm[i])  tag = "R1";
      else if (ov != "")    tag = ov;
      else if (cyc < E)     tag = "R2";
      else if (cyc >= R)    tag = "R5";
      else if (!lmd)        tag = "R3";
      else if (pre)         tag = "R7";
      else                  tag = "R4";
      cmp(tag, i, {dif_t[i], dif_c[i], dif_t_oe[i], dif_c_oe[i]}, exp);
    end
  endtask

  task automatic run_sc(input int s);
    string ov;
    ov = ((SC_MASK2[s] != SC_MASK[s]) || (SC_MODE2[s] != SC_MODE[s])) ? "R8" : "";
    repeat (SC_GAP[s]) begin @(negedge clk_ref); check_all("R1"); end
    lm = SC_MASK[s]; lmd = SC_MODE[s];
    cfg_stoppable = SC_MASK[s]; cfg_park_float = SC_MODE[s];
    stop_req_a = 1'b1;
    E = cyc[0] ? cyc + 4 : cyc + 3;
    R = BIG; r = BIG; pre_end = -1;
    while (cyc < E + SC_HOLD[s]) begin
      @(negedge clk_ref); check_all(ov);
      if (cyc == E + 1) begin cfg_stoppable = SC_MASK2[s]; cfg_park_float = SC_MODE2[s]; end
    end
    stop_req_a = 1'b0; r = cyc;
    if (SC_RSTOP[s]) begin
      pre_end = r + 2;
      @(negedge clk_ref); check_all("R9");
      stop_req_a = 1'b1;
      repeat (8) begin @(negedge clk_ref); check_all("R9"); end
      stop_req_a = 1'b0; r = cyc;
    end
    R = r[0] ? r + 5 : r + 6;
    pre_end = R - 1;
    while (cyc < R + 4) begin
      @(negedge clk_ref); check_all(ov);
      if (cyc == R) begin
        // R6: every pair restarts on the same edge, true low and complement high
        cmp("R6", N, {dif_t == '0, dif_c == '1, &dif_t_oe, &dif_c_oe}, 4'b1111);
      end
    end
    E = BIG; R = BIG; r = BIG; pre_end = -1;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_ref);
    @(negedge clk_ref);
    for (int i = 0; i < N; i++)
      cmp("R10", i, {dif_t[i], dif_c[i], dif_t_oe[i], dif_c_oe[i]}, 4'b0111);
    stop_req_a = 1'b1;
    @(negedge clk_ref);
    for (int i = 0; i < N; i++)
      cmp("R10", i, {dif_t[i], dif_c[i], dif_t_oe[i], dif_c_oe[i]}, 4'b0111);
    stop_req_a = 1'b0;
    repeat (3) @(negedge clk_ref);
    rst_n = 1'b1;
    repeat (4) begin @(negedge clk_ref); check_all("R1"); end
    for (int s = 0; s < NSC; s++) run_sc(s);
    repeat (3) begin @(negedge clk_ref); check_all("R1"); end
    finish_run();
  end
endmodule